// File: doc/BRIEF.md
# Programmable Integer Divider with Trigger Pulse Train

This block divides a fast input clock by a programmable integer. A five-bit count is compared against a ratio word so that the divided output has a duty cycle near one half. In the same output period it also drives a run of input-clock-wide trigger strobes whose length is set by a second control word. A downstream phase selector uses these strobes.

The count is pipelined. The carry is registered where it crosses from the low three bits to the high bits, and the low bits are delayed to line up with the high part. The restart compare is registered twice. To cover these latencies, the ratio word is reduced by four before it reaches the compares, and the strobe enable runs through a four-register delay line. The resulting division ratio equals the programmed word.

Control words outside their legal range are forced into it. A registered flag reports that this happened.

Top module: `prog_div_pulse`

## Requirements
- R1: While `rst_n` is low, `div_o`, `pulse_o` and `clamp_o` are all 0, including when reset is asserted in the middle of operation.
- R2: In steady state, successive rising edges of `div_o` are exactly N input-clock cycles apart, where N is the effective ratio (5 to 31).
- R3: In each output period `div_o` is high for exactly ceil(N/2) cycles, starting at the rising edge.
- R4: In steady state, each output period contains exactly F cycles with `pulse_o` high, where F is the effective pulse count (1 to N-4). The window runs from one rising edge of `div_o` (inclusive) to the next (exclusive).
- R5: A ratio word below 5 is treated as 5, and `clamp_o` reads 1 one cycle after such a word is applied.
- R6: A pulse-count word of 0 is treated as 1. A pulse-count word above N-4 is treated as N-4. In both cases `clamp_o` reads 1.
- R7: When both words are inside their legal ranges, `clamp_o` is 0.
- R8: After reset is released, `div_o` first goes high immediately after the N-th rising clock edge.
- R9: The pipelined count advances by exactly one per cycle, or restarts at zero. It always reads zero in the cycle after a restart and in the cycle where `div_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 5 | Requested division ratio N |
| pulses_i | input | 5 | Requested trigger strobes per output period F |
| div_o | output | 1 | Divided clock |
| pulse_o | output | 1 | Trigger strobe, one input cycle wide per count |
| clamp_o | output | 1 | Registered flag: a control word was forced into range |

## Verification
The ratio is run at its floor (5), its ceiling (31), odd and even values, and a mid value of 16. Odd and even ratios separate the rounding of the high time. The floor and ceiling ratios expose off-by-one errors in the four-cycle compensation. The pulse count is set to 1 and to its maximum of N-4. These two settings separate an inclusive window bound from an exclusive one, and they show whether strobes that spill past a rising edge are still counted in their own period. Illegal words (ratio 0 or 3, pulse count 0 or above N-4) check that clamping and the flag behave correctly, and the reference case of ratio 10 with 3 strobes anchors the timing of the first edge after reset.

// File: rtl/prog_div_pkg.sv
package prog_div_pkg;
  localparam int CNT_W     = 5;              // ramp / control word width
  localparam int LO_W      = 3;              // bits below the carry pipeline cut
  localparam int HI_W      = CNT_W - LO_W;   // bits above the cut
  localparam int ADJ       = 4;              // loop latency subtracted from ratio
  localparam int RATIO_MIN = ADJ + 1;
  localparam int RATIO_MAX = (1 << CNT_W) - 1;
  localparam int ADJ_MAX   = RATIO_MAX - ADJ;

  typedef logic [CNT_W-1:0] word_t;

  // Ratio forced into [RATIO_MIN, RATIO_MAX]
  function automatic word_t ratio_fix(input word_t r);
    return (r < word_t'(RATIO_MIN)) ? word_t'(RATIO_MIN) : r;
  endfunction

  // Compare value for the restart comparator
  function automatic word_t adj_of(input word_t r);
    return r - word_t'(ADJ);
  endfunction

  // Compare value for the falling edge: ceil(a/2)
  function automatic word_t half_of(input word_t a);
    logic [CNT_W:0] t;
    t = {1'b0, a} + 1'b1;
    return t[CNT_W:1];
  endfunction

  // Pulse count forced into [1, a]
  function automatic word_t frac_fix(input word_t f, input word_t a);
    if (f == '0) return word_t'(1);
    if (f > a)   return a;
    return f;
  endfunction
endpackage

// File: rtl/pdiv_cfg.sv
module pdiv_cfg
  import prog_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t ratio_i,
  input  word_t pulses_i,
  output word_t cfg_a_o,
  output word_t cfg_h_o,
  output word_t cfg_f_o,
  output logic  clamp_o
);
  word_t ratio_ok, a_next, f_next;
  logic  clamp_next;

  always_comb begin
    ratio_ok   = ratio_fix(ratio_i);
    a_next     = adj_of(ratio_ok);
    f_next     = frac_fix(pulses_i, a_next);
    clamp_next = (ratio_ok != ratio_i) || (f_next != pulses_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a_o <= word_t'(ADJ_MAX);
      cfg_h_o <= half_of(word_t'(ADJ_MAX));
      cfg_f_o <= word_t'(1);
      clamp_o <= 1'b0;
    end else begin
      cfg_a_o <= a_next;
      cfg_h_o <= half_of(a_next);
      cfg_f_o <= f_next;
      clamp_o <= clamp_next;
    end
  end

  // R6
  cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_f_o != '0) && (cfg_f_o <= cfg_a_o) && (cfg_a_o != '0));

  // R5
  ratio_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_i < word_t'(RATIO_MIN)) |=> clamp_o);
endmodule

// File: rtl/pdiv_counter.sv
module pdiv_counter
  import prog_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_i,
  output word_t cnt_o
);
  logic [LO_W-1:0] lo_q, lo_d_q;
  logic [HI_W-1:0] hi_q;
  logic            cy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      lo_d_q <= '0;
      hi_q   <= '0;
      cy_q   <= 1'b0;
    end else if (clr_i) begin
      lo_q   <= '0;
      lo_d_q <= '0;
      hi_q   <= '0;
      cy_q   <= 1'b0;
    end else begin
      lo_q   <= lo_q + 1'b1;
      lo_d_q <= lo_q;                // deskew low part to the high part
      cy_q   <= &lo_q;               // pipelined carry across the cut
      hi_q   <= hi_q + HI_W'(cy_q);
    end
  end

  assign cnt_o = {hi_q, lo_d_q};

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '0) || (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/pdiv_edge.sv
module pdiv_edge
  import prog_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t cnt_i,
  input  word_t cfg_a_i,
  input  word_t cfg_h_i,
  output logic  clr_o,
  output logic  div_o
);
  logic hit_end, hit_half;
  logic end_q, clr_q, div_q;

  assign hit_end  = (cnt_i == cfg_a_i);
  assign hit_half = (cnt_i == cfg_h_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= 1'b0;
      clr_q <= 1'b0;
      div_q <= 1'b0;
    end else begin
      end_q <= hit_end;
      clr_q <= end_q;
      if (clr_q)         div_q <= 1'b1;
      else if (hit_half) div_q <= 1'b0;
    end
  end

  assign clr_o = clr_q;
  assign div_o = div_q;

  // R3
  fall_at_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_o) |-> ($past(cnt_i) == $past(cfg_h_i)));
endmodule

// File: rtl/pdiv_pulse.sv
module pdiv_pulse
  import prog_div_pkg::*;
#(
  parameter int PULSE_DLY = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t cnt_i,
  input  word_t cfg_f_i,
  output logic  pulse_o
);
  logic                 win;
  logic [PULSE_DLY-1:0] dly_q;

  assign win = (cnt_i != '0) && (cnt_i <= cfg_f_i);

  for (genvar g = 0; g < PULSE_DLY; g++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dly_q[g] <= 1'b0;
      else if (g == 0) dly_q[g] <= win;
      else             dly_q[g] <= dly_q[(g == 0) ? 0 : g-1];
    end
  end

  assign pulse_o = dly_q[PULSE_DLY-1];
endmodule

// File: rtl/prog_div_pulse.sv
module prog_div_pulse
  import prog_div_pkg::*;
#(
  parameter int PULSE_DLY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic [CNT_W-1:0] pulses_i,
  output logic             div_o,
  output logic             pulse_o,
  output logic             clamp_o
);
  word_t cfg_a, cfg_h, cfg_f, cnt_w;
  logic  clr_w;

  pdiv_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .ratio_i(ratio_i), .pulses_i(pulses_i),
    .cfg_a_o(cfg_a), .cfg_h_o(cfg_h), .cfg_f_o(cfg_f), .clamp_o(clamp_o)
  );

  pdiv_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .cnt_o(cnt_w)
  );

  pdiv_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_w), .cfg_a_i(cfg_a),
    .cfg_h_i(cfg_h), .clr_o(clr_w), .div_o(div_o)
  );

  pdiv_pulse #(.PULSE_DLY(PULSE_DLY)) u_pulse (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_w), .cfg_f_i(cfg_f),
    .pulse_o(pulse_o)
  );

  // R9
  rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_o) |-> (cnt_w == '0));
endmodule

// File: tb/prog_div_pulse_tb_top.sv
`timescale 1ns/1ps
module prog_div_pulse_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] ratio_i, pulses_i;
  logic       div_o, pulse_o, clamp_o;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       last_div = 1'b0;

  always #4 clk = ~clk;

  prog_div_pulse dut_i (
    .clk(clk), .rst_n(rst_n), .ratio_i(ratio_i), .pulses_i(pulses_i),
    .div_o(div_o), .pulse_o(pulse_o), .clamp_o(clamp_o)
  );

  // ratio, pulses, exp period, exp high, exp strobes, exp flag
  localparam int NV = 11;
  localparam int VEC [NV][6] = '{
    '{10,  3, 10,  5,  3, 0},
    '{ 5,  1,  5,  3,  1, 0},
    '{31, 27, 31, 16, 27, 0},
    '{31,  1, 31, 16,  1, 0},
    '{ 7,  2,  7,  4,  2, 0},
    '{16, 12, 16,  8, 12, 0},
    '{ 6,  2,  6,  3,  2, 0},
    '{ 3,  1,  5,  3,  1, 1},
    '{ 0,  0,  5,  3,  1, 1},
    '{12,  0, 12,  6,  1, 1},
    '{12, 20, 12,  6,  8, 1}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic find_rise(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (div_o && !last_div) begin
        last_div = div_o;
        ok = 1'b1;
        break;
      end
      last_div = div_o;
    end
  endtask

  task automatic measure(output int per, output int hi, output int np);
    per = 1; hi = int'(div_o); np = int'(pulse_o);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (div_o && !last_div) begin
        last_div = div_o;
        break;
      end
      per++;
      hi += int'(div_o);
      np += int'(pulse_o);
      last_div = div_o;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int  first_k, per, hi, np;
    bit  ok;
    string tag;
    rst_n = 1'b0; ratio_i = 5'd10; pulses_i = 5'd3;
    repeat (3) @(negedge clk);
    // R1
    check("R1", "div_o in reset", int'(div_o), 0);
    check("R1", "pulse_o in reset", int'(pulse_o), 0);
    check("R1", "clamp_o in reset", int'(clamp_o), 0);
    rst_n = 1'b1;
    first_k = -1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (div_o && first_k < 0) first_k = k;
    end
    // R8: first rise after the 10th edge for ratio 10
    check("R8", "first rise edge index", first_k, 10);

    for (int v = 0; v < NV; v++) begin
      ratio_i  = 5'(VEC[v][0]);
      pulses_i = 5'(VEC[v][1]);
      last_div = div_o;
      find_rise(ok); if (ok) find_rise(ok);
      if (ok) find_rise(ok);
      check("R2", "settle reached rise", int'(ok), 1);
      measure(per, hi, np);
      tag = (VEC[v][5] == 0) ? "R7" : ((VEC[v][0] < 5) ? "R5" : "R6");
      check("R2", $sformatf("period r=%0d f=%0d", VEC[v][0], VEC[v][1]), per, VEC[v][2]);
      check("R3", $sformatf("high time r=%0d", VEC[v][0]), hi, VEC[v][3]);
      check("R4", $sformatf("strobes r=%0d f=%0d", VEC[v][0], VEC[v][1]), np, VEC[v][4]);
      check(tag, $sformatf("clamp flag r=%0d f=%0d", VEC[v][0], VEC[v][1]), int'(clamp_o), VEC[v][5]);
    end

    // R1: reset asserted mid-run clears outputs at once
    ratio_i = 5'd0; pulses_i = 5'd0;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "div_o after mid-run reset", int'(div_o), 0);
    check("R1", "pulse_o after mid-run reset", int'(pulse_o), 0);
    check("R1", "clamp_o after mid-run reset", int'(clamp_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule